// File: doc/BRIEF.md
# Triggered Multi-Wave Sample Player

This block holds several numbered sample sequences in an on-chip sample RAM and replays one of them on demand. A host pushes a wave into the block as a short word stream on a load port. The stream gives the slot number first, then the number of points, then the points themselves. A per-slot table records where each wave starts in the RAM, how long it is, and what its first point is.

A separate select input picks the slot for the next trigger. When the trigger comes, the chosen wave goes out on a 16-bit sample port, paced by a strobe. The strobe's period is set by a divider value that is captured with the trigger. The wave repeats from its first point after its last one and keeps going until a stop or a new trigger. Loads into other slots may run while a wave is playing.

Top module: `wave_player`

## Requirements
- R1: A load is three parts on `ld_data` with `ld_valid` high: a slot word (low 3 bits are the slot, the upper bits are ignored), a point-count word, then exactly that many sample words. A wave loaded this way plays back word for word in load order.
- R2: Storage is handed out in order from address 0. A load is rejected if its count is 0 or if the used words plus the count would exceed the RAM depth. On rejection `load_err` pulses high for one cycle, in the cycle after the count word. The trailing sample words are swallowed, and neither the table nor the used-word total changes.
- R3: `sel_valid` stores `sel_id` as the slot for later triggers. A trigger in the same cycle as `sel_valid` uses the new `sel_id`.
- R4: If `trig` is high for a loaded slot, then in the very next cycle `out_valid` is high, `playing` is high, and `out_data` is the wave's first point.
- R5: During a run, `out_valid` is high once every `rate_div`+1 cycles, so `rate_div`=0 gives a strobe every cycle with no gaps. `rate_div` is captured at the trigger, and later changes do not affect the current run.
- R6: After the last point the output wraps to point 0 and keeps cycling. A one-point wave repeats that point.
- R7: `stop` ends a run: in the next cycle `playing` and `out_valid` are low. A trigger during a run restarts at the first point of the newly chosen wave. A trigger in the same cycle as `stop` takes precedence.
- R8: A trigger on a slot that has never held a successful load pulses `trig_err` in the next cycle, ends any run, and produces no `out_valid`.
- R9: A load whose count word arrives while its slot is the one playing is rejected as in R2. The running output is not disturbed, and the old wave stays stored for that slot.
- R10: A load into another slot during a run leaves the output sequence and its spacing unchanged. The new wave becomes playable once its last word is taken.
- R11: After reset, no slot is loaded, the stored selection is slot 0, the used-word total is 0, and `out_valid`, `playing`, `load_err` and `trig_err` are low.
- R12: Loading a slot that already holds a wave places the new data at the next free addresses. When the last word is taken, the slot points to the new wave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load word present |
| ld_data | input | 16 | Load word: slot, count, or sample |
| sel_valid | input | 1 | Store a new slot selection |
| sel_id | input | 3 | Slot to select |
| rate_div | input | 16 | Strobe period minus one, captured at trigger |
| trig | input | 1 | Start playback of the selected slot |
| stop | input | 1 | End playback |
| out_valid | output | 1 | Sample strobe |
| out_data | output | 16 | Output sample |
| playing | output | 1 | A run is in progress |
| load_err | output | 1 | One-cycle pulse: load rejected |
| trig_err | output | 1 | One-cycle pulse: trigger on an empty slot |

## Verification
The case that is hardest to reach is a load that arrives mid-run. It must be refused when it targets the playing slot and accepted when it targets any other slot, and in both cases the strobe cadence must not change. The bench runs a playback watcher and a load sequence in parallel branches, so the count word arrives several strobes into a run. The watcher checks every cycle of the run against an arithmetic model, and the refused load is confirmed afterwards through a replay and an exact-fill overflow test. A near-complete sweep covers wave lengths 1, 2, 3, 5 and 7 against divider values 0 to 3, which exercises the wrap point at every phase of the strobe.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    LD_SLOT  = 2'd0,
    LD_COUNT = 2'd1,
    LD_DATA  = 2'd2,
    LD_SKIP  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/wp_sample_ram.sv
module wp_sample_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wp_wave_table.sv
module wp_wave_table #(
  parameter int NW  = 8,
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int LW  = 13,
  localparam int IDW = $clog2(NW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit,
  input  logic [IDW-1:0] c_id,
  input  logic [AW-1:0]  c_base,
  input  logic [LW-1:0]  c_len,
  input  logic [DW-1:0]  c_first,
  input  logic [IDW-1:0] q_id,
  output logic           q_valid,
  output logic [AW-1:0]  q_base,
  output logic [LW-1:0]  q_len,
  output logic [DW-1:0]  q_first
);
  logic [NW-1:0] ent_valid;
  logic [AW-1:0] ent_base  [NW];
  logic [LW-1:0] ent_len   [NW];
  logic [DW-1:0] ent_first [NW];

  for (genvar g = 0; g < NW; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
        ent_base[g]  <= '0;
        ent_len[g]   <= '0;
        ent_first[g] <= '0;
      end else if (commit && (c_id == IDW'(g))) begin
        ent_valid[g] <= 1'b1;
        ent_base[g]  <= c_base;
        ent_len[g]   <= c_len;
        ent_first[g] <= c_first;
      end
    end
  end

  always_comb begin
    q_valid = 1'b0;
    q_base  = '0;
    q_len   = '0;
    q_first = '0;
    if (int'(q_id) < NW) begin
      q_valid = ent_valid[q_id];
      q_base  = ent_base[q_id];
      q_len   = ent_len[q_id];
      q_first = ent_first[q_id];
    end
  end
endmodule

// File: rtl/wp_loader.sv
module wp_loader
  import wp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NW    = 8,
  parameter int DEPTH = 4096,
  localparam int IDW  = $clog2(NW),
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_valid,
  input  logic [DW-1:0]  ld_data,
  input  logic           busy,
  input  logic [IDW-1:0] busy_id,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           commit,
  output logic [IDW-1:0] c_id,
  output logic [AW-1:0]  c_base,
  output logic [LW-1:0]  c_len,
  output logic [DW-1:0]  c_first,
  output logic           load_err
);
  ld_state_e      state_q;
  logic [IDW-1:0] slot_q;
  logic [DW-1:0]  rem_q;
  logic [AW-1:0]  wptr_q;
  logic [AW-1:0]  base_q;
  logic [LW-1:0]  len_q;
  logic [LW-1:0]  used_q;
  logic [DW-1:0]  first_q;
  logic           first_pend_q;

  logic [31:0] need;
  logic        reject;
  logic        last_word;

  assign need   = 32'(used_q) + 32'(ld_data);
  assign reject = (ld_data == '0) || (need > 32'(DEPTH)) ||
                  (busy && (busy_id == slot_q));
  assign last_word = (rem_q == DW'(1));

  assign wr_en   = (state_q == LD_DATA) && ld_valid;
  assign wr_addr = wptr_q;
  assign wr_data = ld_data;
  assign commit  = wr_en && last_word;
  assign c_id    = slot_q;
  assign c_base  = base_q;
  assign c_len   = len_q;
  assign c_first = first_pend_q ? ld_data : first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= LD_SLOT;
      slot_q       <= '0;
      rem_q        <= '0;
      wptr_q       <= '0;
      base_q       <= '0;
      len_q        <= '0;
      used_q       <= '0;
      first_q      <= '0;
      first_pend_q <= 1'b0;
      load_err     <= 1'b0;
    end else begin
      load_err <= 1'b0;
      if (ld_valid) begin
        unique case (state_q)
          LD_SLOT: begin
            slot_q  <= ld_data[IDW-1:0];
            state_q <= LD_COUNT;
          end
          LD_COUNT: begin
            rem_q <= ld_data;
            if (reject) begin
              load_err <= 1'b1;
              state_q  <= (ld_data == '0) ? LD_SLOT : LD_SKIP;
            end else begin
              wptr_q       <= used_q[AW-1:0];
              base_q       <= used_q[AW-1:0];
              len_q        <= LW'(ld_data);
              first_pend_q <= 1'b1;
              state_q      <= LD_DATA;
            end
          end
          LD_DATA: begin
            if (first_pend_q) first_q <= ld_data;
            first_pend_q <= 1'b0;
            rem_q        <= rem_q - DW'(1);
            wptr_q       <= wptr_q + AW'(1);
            if (last_word) begin
              used_q  <= used_q + len_q;
              state_q <= LD_SLOT;
            end
          end
          LD_SKIP: begin
            rem_q <= rem_q - DW'(1);
            if (last_word) state_q <= LD_SLOT;
          end
          default: state_q <= LD_SLOT;
        endcase
      end
    end
  end
endmodule

// File: rtl/wp_player.sv
module wp_player #(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int LW  = 13,
  parameter int IDW = 3,
  parameter int RW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_valid,
  input  logic [IDW-1:0] sel_id,
  input  logic [RW-1:0]  rate_div,
  input  logic           trig,
  input  logic           stop,
  output logic [IDW-1:0] look_id,
  input  logic           look_valid,
  input  logic [AW-1:0]  look_base,
  input  logic [LW-1:0]  look_len,
  input  logic [DW-1:0]  look_first,
  output logic           ram_re,
  output logic [AW-1:0]  ram_addr,
  input  logic [DW-1:0]  ram_q,
  output logic           out_valid,
  output logic [DW-1:0]  out_data,
  output logic           playing,
  output logic [IDW-1:0] play_id,
  output logic           trig_err
);
  function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] idx,
                                             input logic [LW-1:0] len);
    if ((LW'(idx) + LW'(1)) >= len) return '0;
    return idx + AW'(1);
  endfunction

  logic [IDW-1:0] sel_q;
  logic [AW-1:0]  base_q;
  logic [LW-1:0]  len_q;
  logic [RW-1:0]  div_q;
  logic [RW-1:0]  cnt_q;
  logic [AW-1:0]  fidx_q;

  logic [AW-1:0] idx1;
  logic          start_ok;
  logic          strobe;

  assign look_id  = sel_valid ? sel_id : sel_q;
  assign idx1     = step_idx('0, look_len);
  assign start_ok = trig && look_valid;
  assign strobe   = playing && !trig && !stop && (cnt_q == '0);
  assign ram_re   = start_ok || strobe;
  assign ram_addr = trig ? (look_base + idx1) : (base_q + fidx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      base_q    <= '0;
      len_q     <= '0;
      div_q     <= '0;
      cnt_q     <= '0;
      fidx_q    <= '0;
      play_id   <= '0;
      playing   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      trig_err  <= 1'b0;
    end else begin
      if (sel_valid) sel_q <= sel_id;
      trig_err <= trig && !look_valid;
      if (trig) begin
        if (look_valid) begin
          playing   <= 1'b1;
          play_id   <= look_id;
          base_q    <= look_base;
          len_q     <= look_len;
          div_q     <= rate_div;
          cnt_q     <= rate_div;
          fidx_q    <= step_idx(idx1, look_len);
          out_valid <= 1'b1;
          out_data  <= look_first;
        end else begin
          playing   <= 1'b0;
          out_valid <= 1'b0;
        end
      end else if (stop) begin
        playing   <= 1'b0;
        out_valid <= 1'b0;
      end else if (playing) begin
        if (cnt_q == '0) begin
          out_valid <= 1'b1;
          out_data  <= ram_q;
          fidx_q    <= step_idx(fidx_q, len_q);
          cnt_q     <= div_q;
        end else begin
          out_valid <= 1'b0;
          cnt_q     <= cnt_q - RW'(1);
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wave_player.sv
module wave_player #(
  parameter int DW        = 16,
  parameter int NUM_WAVES = 8,
  parameter int RAM_DEPTH = 4096,
  parameter int RW        = 16,
  localparam int IDW      = $clog2(NUM_WAVES),
  localparam int AW       = $clog2(RAM_DEPTH),
  localparam int LW       = $clog2(RAM_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_valid,
  input  logic [DW-1:0]  ld_data,
  input  logic           sel_valid,
  input  logic [IDW-1:0] sel_id,
  input  logic [RW-1:0]  rate_div,
  input  logic           trig,
  input  logic           stop,
  output logic           out_valid,
  output logic [DW-1:0]  out_data,
  output logic           playing,
  output logic           load_err,
  output logic           trig_err
);
  logic           wr_en;
  logic [AW-1:0]  wr_addr;
  logic [DW-1:0]  wr_data;
  logic           commit;
  logic [IDW-1:0] c_id;
  logic [AW-1:0]  c_base;
  logic [LW-1:0]  c_len;
  logic [DW-1:0]  c_first;
  logic [IDW-1:0] look_id;
  logic           look_valid;
  logic [AW-1:0]  look_base;
  logic [LW-1:0]  look_len;
  logic [DW-1:0]  look_first;
  logic           ram_re;
  logic [AW-1:0]  ram_addr;
  logic [DW-1:0]  ram_q;
  logic [IDW-1:0] play_id;

  wp_loader #(.DW(DW), .NW(NUM_WAVES), .DEPTH(RAM_DEPTH)) u_load (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_data(ld_data),
    .busy(playing), .busy_id(play_id),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .c_id(c_id), .c_base(c_base), .c_len(c_len),
    .c_first(c_first), .load_err(load_err)
  );

  wp_wave_table #(.NW(NUM_WAVES), .DW(DW), .AW(AW), .LW(LW)) u_tab (
    .clk(clk), .rst(rst), .commit(commit), .c_id(c_id), .c_base(c_base),
    .c_len(c_len), .c_first(c_first), .q_id(look_id), .q_valid(look_valid),
    .q_base(look_base), .q_len(look_len), .q_first(look_first)
  );

  wp_sample_ram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(ram_re), .raddr(ram_addr), .rdata(ram_q)
  );

  wp_player #(.DW(DW), .AW(AW), .LW(LW), .IDW(IDW), .RW(RW)) u_play (
    .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_id(sel_id),
    .rate_div(rate_div), .trig(trig), .stop(stop),
    .look_id(look_id), .look_valid(look_valid), .look_base(look_base),
    .look_len(look_len), .look_first(look_first),
    .ram_re(ram_re), .ram_addr(ram_addr), .ram_q(ram_q),
    .out_valid(out_valid), .out_data(out_data), .playing(playing),
    .play_id(play_id), .trig_err(trig_err)
  );
endmodule

// File: rtl/wp_chk.sv
module wp_chk #(
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_valid,
  input logic          trig,
  input logic          stop,
  input logic [RW-1:0] rate_div,
  input logic          out_valid,
  input logic          playing,
  input logic          load_err,
  input logic          trig_err
);
  logic [RW-1:0] div_seen;

  always_ff @(posedge clk) begin
    if (rst) div_seen <= '0;
    else if (trig) div_seen <= rate_div;
  end

  // R4
  trig_resp_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> (out_valid || trig_err));

  // R8
  empty_slot_silent_chk: assert property (@(posedge clk) disable iff (rst)
    trig_err |-> (!out_valid && !playing));

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !trig) |=> (!out_valid && !playing));

  // R5
  gapless_chk: assert property (@(posedge clk) disable iff (rst)
    (playing && (div_seen == '0) && !stop && !trig) |=> out_valid);

  // R5
  strobe_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> playing);

  // R2
  load_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    load_err |-> $past(ld_valid));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trig_err |-> $past(trig));
endmodule

bind wave_player wp_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .trig(trig), .stop(stop),
  .rate_div(rate_div), .out_valid(out_valid), .playing(playing),
  .load_err(load_err), .trig_err(trig_err)
);

// File: tb/sim_wave_player.sv
module sim_wave_player;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid;
  logic [15:0] ld_data;
  logic        sel_valid;
  logic [2:0]  sel_id;
  logic [15:0] rate_div;
  logic        trig;
  logic        stop;
  logic        out_valid;
  logic [15:0] out_data;
  logic        playing;
  logic        load_err;
  logic        trig_err;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  wave_player #(.DW(16), .NUM_WAVES(8), .RAM_DEPTH(64), .RW(16)) u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_data(ld_data),
    .sel_valid(sel_valid), .sel_id(sel_id), .rate_div(rate_div),
    .trig(trig), .stop(stop), .out_valid(out_valid), .out_data(out_data),
    .playing(playing), .load_err(load_err), .trig_err(trig_err)
  );

  function automatic logic [15:0] smp(input logic [7:0] tag, input int k);
    return {tag, 8'(k * 5 + 3)};
  endfunction

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic load(input int id, input int n, input logic [7:0] tag,
                      output logic err);
    @(negedge clk); ld_valid = 1'b1; ld_data = 16'(id) | 16'h0a00;
    @(negedge clk); ld_data = 16'(n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) err = load_err;
      ld_data = smp(tag, k);
    end
    @(negedge clk);
    if (n == 0) err = load_err;
    ld_valid = 1'b0;
  endtask

  task automatic watch(input int id, input int len, input int dv,
                       input logic [7:0] tag, input int ncyc, input string rq);
    int miss = 0;
    logic [15:0] ev;
    @(negedge clk); sel_valid = 1'b1; sel_id = 3'(id); trig = 1'b1; rate_div = 16'(dv);
    @(negedge clk); sel_valid = 1'b0; trig = 1'b0;
    chk(out_valid && playing && out_data == smp(tag, 0), "R4", int'(out_data), int'(smp(tag, 0)));
    for (int t = 1; t <= ncyc; t++) begin
      if (t > 1) @(negedge clk);
      if ((t - 1) % (dv + 1) == 0) begin
        ev = smp(tag, ((t - 1) / (dv + 1)) % len);
        if (!out_valid || out_data != ev) begin
          if (miss == 0) $display("  slot %0d cycle %0d: got %h/%0d want %h", id, t, out_data, out_valid, ev);
          miss++;
        end
      end else if (out_valid) begin
        miss++;
      end
    end
    chk(miss == 0, rq, miss, 0);
  endtask

  task automatic halt(input string rq);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!playing && !out_valid, rq, int'(playing), 0);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic e;
    int   ids  [5] = '{0, 1, 2, 3, 5};
    int   lens [5] = '{1, 2, 3, 5, 7};
    rst = 1'b1; ld_valid = 1'b0; ld_data = '0; sel_valid = 1'b0; sel_id = '0;
    rate_div = '0; trig = 1'b0; stop = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!out_valid && !playing && !load_err && !trig_err, "R11", int'(out_valid), 0);
    // R11: slot 0 selected and empty
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(trig_err && !out_valid && !playing, "R11", int'(trig_err), 1);

    // R1 loads
    for (int i = 0; i < 5; i++) begin
      load(ids[i], lens[i], 8'(8'h10 + i), e);
      chk(!e, "R1", int'(e), 0);
    end

    // R1 R5 R6 sweep over lengths and dividers
    for (int i = 0; i < 5; i++) begin
      for (int dv = 0; dv < 4; dv++) begin
        watch(ids[i], lens[i], dv, 8'(8'h10 + i), 2 * lens[i] * (dv + 1) + 2, "R6");
        halt("R7");
      end
    end

    // R3 selection stored ahead of trigger
    @(negedge clk); sel_valid = 1'b1; sel_id = 3'd3;
    @(negedge clk); sel_valid = 1'b0;
    repeat (2) @(negedge clk);
    trig = 1'b1; rate_div = '0;
    @(negedge clk); trig = 1'b0;
    chk(out_valid && out_data == smp(8'h13, 0), "R3", int'(out_data), int'(smp(8'h13, 0)));
    @(negedge clk);
    chk(out_valid && out_data == smp(8'h13, 1), "R3", int'(out_data), int'(smp(8'h13, 1)));

    // R7 retrigger mid-run restarts on new wave
    watch(3, 5, 1, 8'h13, 5, "R7");
    watch(5, 7, 0, 8'h14, 9, "R7");

    // R8 trigger of empty slot during a run
    @(negedge clk); sel_valid = 1'b1; sel_id = 3'd7; trig = 1'b1;
    @(negedge clk); sel_valid = 1'b0; trig = 1'b0;
    chk(trig_err && !out_valid && !playing, "R8", int'(trig_err), 1);
    repeat (3) begin
      @(negedge clk);
      chk(!out_valid && !playing, "R8", int'(out_valid), 0);
    end

    // R5 divider captured at trigger
    fork
      watch(3, 5, 2, 8'h13, 24, "R5");
      begin repeat (6) @(negedge clk); rate_div = 16'd0; end
    join
    halt("R7");

    // R9 load to the playing slot is refused
    fork
      watch(2, 3, 1, 8'h12, 30, "R9");
      begin
        repeat (4) @(negedge clk);
        load(2, 2, 8'h22, e);
        chk(e, "R9", int'(e), 1);
      end
    join
    halt("R7");
    watch(2, 3, 0, 8'h12, 7, "R9");
    halt("R7");

    // R10 concurrent load into another slot
    fork
      watch(3, 5, 0, 8'h13, 24, "R10");
      begin
        repeat (3) @(negedge clk);
        load(4, 4, 8'h44, e);
        chk(!e, "R10", int'(e), 0);
      end
    join
    halt("R7");
    watch(4, 4, 1, 8'h44, 17, "R10");
    halt("R7");

    // R12 reload replaces slot content
    load(1, 3, 8'h31, e);
    chk(!e, "R12", int'(e), 0);
    watch(1, 3, 0, 8'h31, 8, "R12");
    halt("R7");

    // R2 capacity: 25 words used of 64
    load(6, 40, 8'h66, e);
    chk(e, "R2", int'(e), 1);
    @(negedge clk); sel_valid = 1'b1; sel_id = 3'd6; trig = 1'b1;
    @(negedge clk); sel_valid = 1'b0; trig = 1'b0;
    chk(trig_err && !out_valid, "R2", int'(trig_err), 1);
    load(6, 39, 8'h67, e);
    chk(!e, "R2", int'(e), 0);
    watch(6, 39, 0, 8'h67, 80, "R2");
    halt("R7");
    load(7, 1, 8'h77, e);
    chk(e, "R2", int'(e), 1);
    load(7, 0, 8'h78, e);
    chk(e, "R2", int'(e), 1);
    // R2 slot 7 still empty after both rejections
    @(negedge clk); sel_valid = 1'b1; sel_id = 3'd7; trig = 1'b1;
    @(negedge clk); sel_valid = 1'b0; trig = 1'b0;
    chk(trig_err && !out_valid, "R2", int'(trig_err), 1);

    // R6 R7 stop and trigger together: trigger wins
    @(negedge clk); sel_valid = 1'b1; sel_id = 3'd0; trig = 1'b1; stop = 1'b1; rate_div = '0;
    @(negedge clk); sel_valid = 1'b0; trig = 1'b0; stop = 1'b0;
    chk(out_valid && playing && out_data == smp(8'h10, 0), "R7", int'(out_data), int'(smp(8'h10, 0)));
    @(negedge clk);
    chk(out_valid && out_data == smp(8'h10, 0), "R6", int'(out_data), int'(smp(8'h10, 0)));
    halt("R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule